// File: doc/BRIEF.md
# Pulsed Radar Acquisition Sequencer

This block produces the timing of a pulsed radar's transmit-then-listen cycle. A trigger from the pulse repetition source starts a cycle. The block then raises a transmit gate for a programmed number of clock ticks. After a programmed delay it opens an acquisition window that qualifies incoming sample words, and it keeps the window open for a programmed record length. A one-cycle done pulse marks the end of each cycle.

The delay and the record length are normally derived from range limits. The round-trip time is twice the range divided by the propagation speed of 300,000 km/s. A 15 km minimum range therefore opens the window 100 µs after the trigger, and a 45 km maximum range closes it at 300 µs, which gives a 200 µs record. A short-range entry and a long-range entry can each be a separate cycle.

A small table holds the cycle entries. Each entry gives the pulse width, the acquisition delay, the record length, the minimum cycle period, a wrap flag and an overlap-permit flag. The table is loaded through a write port. The sequencer uses one entry per cycle and steps through the table, so that different scenarios run back to back. When software clears the enable, the sequencer finishes the running cycle and parks at entry 0.

Top module: `radar_acq_sequencer`

## Requirements
- R1: After reset, txGate, acqValid and cycleDone are low, overrun is low and entryIdx is 0.
- R2: A trigger sampled high on a clock edge while the block is idle and enable is high starts a cycle. Count the cycle's clock periods as k = 0, 1, … from that edge. txGate is high exactly for k < pulse width, so a width of 0 gives no gate.
- R3: When the entry's overlap-permit flag is 1, the window start S equals the acquisition delay. acqValid is high exactly for S <= k < S + record length, which is record-length cycles per pulse, and none for a length of 0.
- R4: When the overlap-permit flag is 0, S is the larger of the acquisition delay and the pulse width, so acqValid and txGate are never high together.
- R5: The cycle lasts E = max(period, pulse width, S + record length, 1) cycles. cycleDone is a single-cycle pulse at k = E-1, and the block is idle at k = E.
- R6: After each cycle entryIdx becomes 0 if the finished entry's wrap flag is 1, or if it was the last table slot. Otherwise entryIdx increments by 1. Each cycle uses the entry selected by entryIdx when it starts.
- R7: A trigger high while a cycle runs is ignored: the running cycle keeps its length and the index advances once. Such a trigger sets overrun, which stays high until reset.
- R8: When enable is low at the end of a cycle, the cycle still completes. entryIdx then returns to 0. While enable stays low, triggers start no cycle and do not set overrun.
- R9: A table write during a running cycle does not change that cycle. The written values take effect when that slot next starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low finishes the current cycle and parks at entry 0 |
| trigger | input | 1 | Pulse repetition trigger, sampled on the rising edge |
| cfgWrEn | input | 1 | Table write strobe |
| cfgWrAddr | input | IDX_W | Table slot to write |
| cfgPulseWidth | input | CNT_W | Transmit gate width in ticks |
| cfgAcqDelay | input | CNT_W | Window start delay from the trigger in ticks |
| cfgRecLen | input | CNT_W | Window length in ticks |
| cfgPeriod | input | CNT_W | Minimum cycle length in ticks |
| cfgLast | input | 1 | Wrap flag: the index returns to 0 after this slot |
| cfgOverlap | input | 1 | Permits the window to overlap the transmit gate |
| txGate | output | 1 | Transmit gate |
| acqValid | output | 1 | Sample qualifier for the acquisition window |
| cycleDone | output | 1 | One-cycle pulse on the last tick of a cycle |
| overrun | output | 1 | Sticky flag for a trigger that arrives during a cycle |
| entryIdx | output | IDX_W | Table slot used by the next cycle |

## Verification
The main sweep runs a single wrapping entry through every combination of three pulse widths, three delays, three record lengths, two periods and both overlap settings. Each cycle is compared tick by tick against the gate, the window and the end computed from the formulas. The mix of zero widths, zero lengths, delays shorter and longer than the pulse, and periods shorter and longer than the window tells the forced window start apart from the programmed one. It also tells a period-bound cycle end apart from a window-bound one. Separate patterns cover a three-entry sequence with a wrap, a trigger during a running cycle, a table rewrite in the middle of a cycle, and enable dropping mid-cycle. Each of these separates stepping the index from restarting or corrupting the cycle.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startCycle;  // latch the selected entry and clear the tick counter
    logic stepIdx;     // advance the table index after a finished cycle
    logic clearIdx;    // park the index at slot 0
    logic running;     // a cycle is in progress
  } seqStrobe_t;
endpackage

// File: rtl/acq_seq_datapath.sv
module acq_seq_datapath
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrPulse,
  input  logic [CNT_W-1:0] wrDelay,
  input  logic [CNT_W-1:0] wrLen,
  input  logic [CNT_W-1:0] wrPeriod,
  input  logic             wrLast,
  input  logic             wrOverlap,
  input  seqStrobe_t       strobe,
  output logic             txGate,
  output logic             acqValid,
  output logic             endHit,
  output logic [IDX_W-1:0] curIdx
);
  // Parameter table
  logic [CNT_W-1:0] tPulse  [DEPTH];
  logic [CNT_W-1:0] tDelay  [DEPTH];
  logic [CNT_W-1:0] tLen    [DEPTH];
  logic [CNT_W-1:0] tPeriod [DEPTH];
  logic [DEPTH-1:0] tLast;
  logic [DEPTH-1:0] tOverlap;

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tPulse[i]   <= '0;
        tDelay[i]   <= '0;
        tLen[i]     <= '0;
        tPeriod[i]  <= '0;
        tLast[i]    <= 1'b1;
        tOverlap[i] <= 1'b0;
      end else if (wrEn && wrAddr == IDX_W'(i)) begin
        tPulse[i]   <= wrPulse;
        tDelay[i]   <= wrDelay;
        tLen[i]     <= wrLen;
        tPeriod[i]  <= wrPeriod;
        tLast[i]    <= wrLast;
        tOverlap[i] <= wrOverlap;
      end
    end
  end

  // Entry latched for the running cycle
  logic [CNT_W-1:0] lPulse, lDelay, lLen, lPeriod;
  logic             lLast, lOverlap;
  logic [SUM_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lPulse   <= '0;
      lDelay   <= '0;
      lLen     <= '0;
      lPeriod  <= '0;
      lLast    <= 1'b0;
      lOverlap <= 1'b0;
      tickCnt  <= '0;
    end else if (strobe.startCycle) begin
      lPulse   <= tPulse[curIdx];
      lDelay   <= tDelay[curIdx];
      lLen     <= tLen[curIdx];
      lPeriod  <= tPeriod[curIdx];
      lLast    <= tLast[curIdx];
      lOverlap <= tOverlap[curIdx];
      tickCnt  <= '0;
    end else if (strobe.running) begin
      tickCnt  <= tickCnt + 1'b1;
    end
  end

  // Table index stepping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (strobe.clearIdx) begin
      curIdx <= '0;
    end else if (strobe.stepIdx) begin
      if (lLast || curIdx == IDX_W'(DEPTH - 1)) curIdx <= '0;
      else                                     curIdx <= curIdx + 1'b1;
    end
  end

  // Window edges and cycle end
  logic [SUM_W-1:0] pulseExt, delayExt, acqStart, acqStop, cycEnd;

  always_comb begin
    pulseExt = {1'b0, lPulse};
    delayExt = {1'b0, lDelay};
    if (lOverlap || delayExt >= pulseExt) acqStart = delayExt;
    else                                  acqStart = pulseExt;
    acqStop = acqStart + {1'b0, lLen};
    cycEnd  = {1'b0, lPeriod};
    if (pulseExt > cycEnd) cycEnd = pulseExt;
    if (acqStop > cycEnd)  cycEnd = acqStop;
    if (cycEnd == '0)      cycEnd = SUM_W'(1);
  end

  assign txGate   = strobe.running && (tickCnt < pulseExt);
  assign acqValid = strobe.running && (tickCnt >= acqStart) && (tickCnt < acqStop);
  assign endHit   = strobe.running && (tickCnt == cycEnd - 1'b1);

  // Assertions
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (txGate && !lOverlap) |-> !acqValid);  // R4
  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.running && !strobe.startCycle && !endHit) |=> (tickCnt == $past(tickCnt) + 1'b1));  // R5
  AST_GATE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startCycle |=> (txGate == (lPulse != '0)));  // R2
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       trigger,
  input  logic       endHit,
  output seqStrobe_t strobe,
  output logic       overrun
);
  typedef enum logic { ST_IDLE, ST_RUN } seqState_t;
  seqState_t state;

  always_comb begin
    strobe            = '0;
    strobe.running    = (state == ST_RUN);
    strobe.startCycle = (state == ST_IDLE) && enable && trigger;
    strobe.stepIdx    = (state == ST_RUN) && endHit && enable;
    strobe.clearIdx   = ((state == ST_RUN) && endHit && !enable) ||
                        ((state == ST_IDLE) && !enable);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      overrun <= 1'b0;
    end else begin
      if (strobe.startCycle)             state <= ST_RUN;
      else if (state == ST_RUN && endHit) state <= ST_IDLE;
      if (state == ST_RUN && trigger)    overrun <= 1'b1;
    end
  end

  // Assertions
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    endHit |=> (state == ST_IDLE));  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    endHit |=> !endHit);  // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && trigger) |=> overrun);  // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);  // R7
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));  // R8
endmodule

// File: rtl/radar_acq_sequencer.sv
module radar_acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             trigger,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgWrAddr,
  input  logic [CNT_W-1:0] cfgPulseWidth,
  input  logic [CNT_W-1:0] cfgAcqDelay,
  input  logic [CNT_W-1:0] cfgRecLen,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic             cfgLast,
  input  logic             cfgOverlap,
  output logic             txGate,
  output logic             acqValid,
  output logic             cycleDone,
  output logic             overrun,
  output logic [IDX_W-1:0] entryIdx
);
  seqStrobe_t strobe;
  logic       endHit;

  acq_seq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .trigger (trigger),
    .endHit  (endHit),
    .strobe  (strobe),
    .overrun (overrun)
  );

  acq_seq_datapath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (cfgWrEn),
    .wrAddr    (cfgWrAddr),
    .wrPulse   (cfgPulseWidth),
    .wrDelay   (cfgAcqDelay),
    .wrLen     (cfgRecLen),
    .wrPeriod  (cfgPeriod),
    .wrLast    (cfgLast),
    .wrOverlap (cfgOverlap),
    .strobe    (strobe),
    .txGate    (txGate),
    .acqValid  (acqValid),
    .endHit    (endHit),
    .curIdx    (entryIdx)
  );

  assign cycleDone = endHit;

  AST_PARK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strobe.running) |=> (entryIdx == '0));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.running |-> !(txGate || acqValid || cycleDone));  // R1
endmodule

// File: tb/radar_acq_sequencer_tb_top.sv
module radar_acq_sequencer_tb_top;
  localparam int CNT_W = 16;
  localparam int DEPTH = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, trigger = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IDX_W-1:0] cfgWrAddr = '0;
  logic [CNT_W-1:0] cfgPulseWidth = '0, cfgAcqDelay = '0, cfgRecLen = '0, cfgPeriod = '0;
  logic cfgLast = 1'b0, cfgOverlap = 1'b0;
  logic txGate, acqValid, cycleDone, overrun;
  logic [IDX_W-1:0] entryIdx;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  radar_acq_sequencer #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .trigger(trigger),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgPulseWidth(cfgPulseWidth),
    .cfgAcqDelay(cfgAcqDelay), .cfgRecLen(cfgRecLen), .cfgPeriod(cfgPeriod),
    .cfgLast(cfgLast), .cfgOverlap(cfgOverlap),
    .txGate(txGate), .acqValid(acqValid), .cycleDone(cycleDone),
    .overrun(overrun), .entryIdx(entryIdx)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic writeEntry(input int addr, input int pw, input int dl, input int ln,
                            input int per, input bit last, input bit ov);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = IDX_W'(addr);
    cfgPulseWidth = CNT_W'(pw); cfgAcqDelay = CNT_W'(dl);
    cfgRecLen = CNT_W'(ln); cfgPeriod = CNT_W'(per);
    cfgLast = last; cfgOverlap = ov;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // mode: 0 plain, 1 trigger during cycle (R7), 2 enable drop (R8), 3 table rewrite (R9)
  task automatic runCycle(input int pw, input int dl, input int ln, input int per,
                          input bit ov, input int mode, input int modeAddr);
    int st, sp, en, acqSeen;
    st = ov ? dl : ((dl > pw) ? dl : pw);
    sp = st + ln;
    en = per;
    if (pw > en) en = pw;
    if (sp > en) en = sp;
    if (en < 1) en = 1;
    acqSeen = 0;
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    for (int k = 0; k < en; k++) begin
      chk("R2 txGate", int'(txGate), int'(k < pw));
      chk(ov ? "R3 acqValid" : "R4 acqValid", int'(acqValid), int'(k >= st && k < sp));
      chk("R5 cycleDone", int'(cycleDone), int'(k == en - 1));
      if (acqValid) acqSeen++;
      if (mode == 1 && k == 1) trigger = 1'b1;
      if (mode == 1 && k == 2) trigger = 1'b0;
      if (mode == 2 && k == 1) enable = 1'b0;
      if (mode == 3 && k == 1) begin
        cfgWrEn = 1'b1; cfgWrAddr = IDX_W'(modeAddr);
        cfgPulseWidth = 1; cfgAcqDelay = 1; cfgRecLen = 1; cfgPeriod = 2;
        cfgLast = 1'b1; cfgOverlap = 1'b1;
      end
      if (mode == 3 && k == 2) cfgWrEn = 1'b0;
      @(negedge clk);
    end
    chk("R3 record count", acqSeen, ln);
    chk("R5 idle after end", int'(txGate) + int'(acqValid) + int'(cycleDone), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txGate", int'(txGate), 0);
    chk("R1 acqValid", int'(acqValid), 0);
    chk("R1 cycleDone", int'(cycleDone), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 entryIdx", int'(entryIdx), 0);
    rstN = 1'b1;
    enable = 1'b1;

    // Sweep of one wrapping entry: R2 R3 R4 R5, and R6 wrap on slot 0
    for (int ov = 0; ov < 2; ov++)
      for (int pi = 0; pi < 3; pi++)
        for (int di = 0; di < 3; di++)
          for (int li = 0; li < 3; li++)
            for (int qi = 0; qi < 2; qi++) begin
              int pw, dl, ln, per;
              pw  = (pi == 0) ? 0 : (pi == 1) ? 2 : 5;
              dl  = (di == 0) ? 0 : (di == 1) ? 3 : 6;
              ln  = (li == 0) ? 0 : (li == 1) ? 1 : 4;
              per = (qi == 0) ? 1 : 8;
              writeEntry(0, pw, dl, ln, per, 1'b1, ov[0]);
              runCycle(pw, dl, ln, per, ov[0], 0, 0);
              chk("R6 wrap flag keeps slot 0", int'(entryIdx), 0);
            end

    // R6 three-entry sequence with wrap on slot 2
    writeEntry(0, 2, 3, 2, 6, 1'b0, 1'b0);
    writeEntry(1, 4, 1, 3, 3, 1'b0, 1'b1);
    writeEntry(2, 1, 5, 1, 9, 1'b1, 1'b0);
    runCycle(2, 3, 2, 6, 1'b0, 0, 0);
    chk("R6 index after slot 0", int'(entryIdx), 1);
    runCycle(4, 1, 3, 3, 1'b1, 0, 0);
    chk("R6 index after slot 1", int'(entryIdx), 2);
    runCycle(1, 5, 1, 9, 1'b0, 0, 0);
    chk("R6 index after slot 2", int'(entryIdx), 0);

    // R6 wrap at the last table slot without a wrap flag
    writeEntry(2, 1, 1, 1, 3, 1'b0, 1'b0);
    writeEntry(3, 2, 0, 2, 4, 1'b0, 1'b1);
    runCycle(2, 3, 2, 6, 1'b0, 0, 0);
    runCycle(4, 1, 3, 3, 1'b1, 0, 0);
    runCycle(1, 1, 1, 3, 1'b0, 0, 0);
    chk("R6 index before last slot", int'(entryIdx), 3);
    runCycle(2, 0, 2, 4, 1'b1, 0, 0);
    chk("R6 wrap after last slot", int'(entryIdx), 0);

    // R9 rewrite slot 0 while it runs: this cycle unchanged, next uses new values
    runCycle(2, 3, 2, 6, 1'b0, 3, 0);
    chk("R9 index after rewritten cycle", int'(entryIdx), 1);
    runCycle(4, 1, 3, 3, 1'b1, 0, 0);
    runCycle(1, 1, 1, 3, 1'b0, 0, 0);
    runCycle(2, 0, 2, 4, 1'b1, 0, 0);
    runCycle(1, 1, 1, 2, 1'b1, 0, 0);
    chk("R9 new slot 0 wraps", int'(entryIdx), 0);

    // R8 enable drop mid-cycle from slot 1
    writeEntry(0, 2, 3, 2, 6, 1'b0, 1'b0);
    runCycle(2, 3, 2, 6, 1'b0, 0, 0);
    chk("R8 at slot 1", int'(entryIdx), 1);
    runCycle(4, 1, 3, 3, 1'b1, 2, 0);
    chk("R8 parked at slot 0", int'(entryIdx), 0);
    @(negedge clk);
    trigger = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 no start while disabled", int'(txGate) + int'(acqValid) + int'(cycleDone), 0);
    end
    trigger = 1'b0;
    chk("R8 no overrun while disabled", int'(overrun), 0);
    enable = 1'b1;

    // R7 trigger during a running cycle
    chk("R7 overrun clear before", int'(overrun), 0);
    runCycle(2, 3, 2, 6, 1'b0, 1, 0);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R7 single step", int'(entryIdx), 1);
    runCycle(4, 1, 3, 3, 1'b1, 0, 0);
    chk("R7 overrun sticky", int'(overrun), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule